// File: doc/BRIEF.md
# Register Rename Map with Free List

This block translates architectural register names into physical register numbers for an out-of-order core whose enlarged physical register file holds all in-flight values. Values are not buffered elsewhere. Each cycle it can rename one instruction. The physical names of two source operands are looked up combinationally. If the instruction writes a register, an unused physical register is taken from a free list for the destination. Giving every destination a fresh register removes write-after-write and write-after-read hazards.

Two maps are kept. The speculative map reflects every renamed instruction. The committed map changes only when an instruction retires. A physical register therefore becomes architectural state only at commit. At that point the register previously bound to the same architectural name can no longer be read, and it goes back to the tail of the free list.

When a branch is found to be mispredicted, a single recover pulse copies the committed map over the speculative map. The same pulse rebuilds the free list from every physical register the committed map does not name. The free list is a FIFO of physical indices and `PHYS` must be a power of two.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps, and the free list holds physical registers ARCH to PHYS-1 with the lowest index at its head.
- R2: `src_a_phys` and `src_b_phys` show the speculative mapping of `src_a` and `src_b` in the same cycle. A source equal to the instruction's own destination returns the mapping held before this rename.
- R3: A rename with `dst_en` high while `ren_ready` is high hands out the free-list head on `dst_phys`. It shows the prior speculative mapping of `dst` on `dst_prev` and binds `dst` to `dst_phys` from the next cycle on. With `dst_en` low, nothing is allocated.
- R4: A commit of (`cm_arch`, `cm_phys`) writes `cm_phys` into the committed map. The physical register that the committed map held for `cm_arch` is appended to the tail of the free list.
- R5: `ren_ready` is low exactly when the free list is empty. A rename request in that state changes neither map nor the free list.
- R6: A `recover` pulse makes the speculative map equal to the committed map in the next cycle. Rename and commit requests in the same cycle are ignored.
- R7: After `recover`, the free list holds exactly the physical registers not named by the committed map, in ascending order from the head.
- R8: A rename and a commit in the same cycle both take effect, and the free-list occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| src_a | input | 5 | First source architectural register |
| src_b | input | 5 | Second source architectural register |
| dst_en | input | 1 | Instruction writes a destination |
| dst | input | 5 | Destination architectural register |
| src_a_phys | output | 6 | Physical name of src_a |
| src_b_phys | output | 6 | Physical name of src_b |
| dst_phys | output | 6 | Physical register allocated to dst (free-list head) |
| dst_prev | output | 6 | Speculative mapping of dst before this rename |
| ren_ready | output | 1 | Free list not empty |
| cm_valid | input | 1 | Commit request |
| cm_arch | input | 5 | Architectural register of the committing instruction |
| cm_phys | input | 6 | Physical register it was given at rename |
| recover | input | 1 | Restore speculative state from committed state |

## Verification
On every cycle, the assertions check how occupancy moves. An allocation lowers it by one, a release raises it by one, and both together leave it unchanged. A stalled request leaves the map and the count untouched. A recover copies the committed map and restores the full free count. Only the bench's scenarios can show which registers are handed out and in what order. They also show that sources see earlier renames, that a freed register comes back only after the free list drains past it, and that a rebuild lists the unused registers in ascending order. The bench covers these with a reference model under directed sequences and a long pseudo-random mix of renames, commits and recoveries.

// File: rtl/reg_rename.sv
`timescale 1ns/1ps
module reg_rename #(
  parameter int ARCH = 32,
  parameter int PHYS = 64,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          dst_en,
  input  logic [AW-1:0] dst,
  output logic [PW-1:0] src_a_phys,
  output logic [PW-1:0] src_b_phys,
  output logic [PW-1:0] dst_phys,
  output logic [PW-1:0] dst_prev,
  output logic          ren_ready,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_arch,
  input  logic [PW-1:0] cm_phys,
  input  logic          recover
);

  logic [ARCH-1:0][PW-1:0] spec_map, com_map;
  logic [PHYS-1:0][PW-1:0] fl;
  logic [PW-1:0]           head, tail;
  logic [CW-1:0]           cnt;

  logic [PHYS-1:0]         used;
  logic [PHYS-1:0][PW-1:0] rb_list;
  logic [CW-1:0]           rb_cnt;

  wire pop  = ren_valid & dst_en & (cnt != '0) & ~recover;
  wire push = cm_valid & ~recover;

  assign src_a_phys = spec_map[src_a];
  assign src_b_phys = spec_map[src_b];
  assign dst_prev   = spec_map[dst];
  assign dst_phys   = fl[head];
  assign ren_ready  = cnt != '0;

  always_comb begin
    used    = '0;
    rb_list = '0;
    rb_cnt  = '0;
    for (int a = 0; a < ARCH; a++) used[com_map[a]] = 1'b1;
    for (int p = 0; p < PHYS; p++) begin
      if (!used[p]) begin
        rb_list[rb_cnt[PW-1:0]] = PW'(p);
        rb_cnt = rb_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH; a++) begin
        spec_map[a] <= PW'(a);
        com_map[a]  <= PW'(a);
      end
      for (int i = 0; i < PHYS; i++)
        fl[i] <= (i < PHYS - ARCH) ? PW'(ARCH + i) : '0;
      head <= '0;
      tail <= PW'(PHYS - ARCH);
      cnt  <= CW'(PHYS - ARCH);
    end else if (recover) begin
      spec_map <= com_map;
      fl       <= rb_list;
      head     <= '0;
      tail     <= rb_cnt[PW-1:0];
      cnt      <= rb_cnt;
    end else begin
      if (pop) begin
        spec_map[dst] <= fl[head];
        head <= head + PW'(1);
      end
      if (push) begin
        fl[tail]         <= com_map[cm_arch];
        com_map[cm_arch] <= cm_phys;
        tail <= tail + PW'(1);
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb if (rst_n) a_r5_cnt_range: assert (cnt <= CW'(PHYS));

  a_r3_alloc_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && dst_en && ren_ready && !cm_valid && !recover |=> cnt == $past(cnt) - CW'(1));
  a_r4_release_inc: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !recover && !(ren_valid && dst_en) |=> cnt == $past(cnt) + CW'(1));
  a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && ren_valid && dst_en && ren_ready && !recover |=> $stable(cnt));
  a_r5_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_ready && !cm_valid && !recover |=> $stable(spec_map) && !ren_ready);
  a_r6_map_restore: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> spec_map == $past(com_map));
  a_r7_full_free: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> cnt == CW'(PHYS - ARCH));

endmodule

// File: tb/test_reg_rename.sv
`timescale 1ns/1ps
module test_reg_rename;
  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, dst_en = 0, cm_valid = 0, recover = 0;
  logic [4:0] src_a = 0, src_b = 0, dst = 0, cm_arch = 0;
  logic [5:0] cm_phys = 0;
  logic [5:0] src_a_phys, src_b_phys, dst_phys, dst_prev;
  logic ren_ready;

  int checks = 0, failures = 0;
  bit done = 0;
  int bspec[32], bcom[32];
  int q[$], ra[$], rp[$];
  logic [15:0] lf = 16'hACE1;

  reg_rename i_reg_rename (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rebuild();
    q.delete();
    for (int p = 0; p < 64; p++) begin
      bit u = 0;
      for (int a = 0; a < 32; a++) if (bcom[a] == p) u = 1;
      if (!u) q.push_back(p);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 32; a++) begin bspec[a] = a; bcom[a] = a; end
    q.delete(); ra.delete(); rp.delete();
    for (int p = 32; p < 64; p++) q.push_back(p);
  endtask

  // one cycle: drive, check combinational outputs, clock, update model
  task automatic cyc(input bit rv, input int a, input int b, input bit de, input int d,
                     input bit cv, input bit rc, input string tag);
    int ca = 0, cp = 0;
    @(negedge clk);
    if (cv && ra.size() == 0) cv = 0;
    if (cv) begin ca = ra[0]; cp = rp[0]; end
    ren_valid = rv; src_a = 5'(a); src_b = 5'(b); dst_en = de; dst = 5'(d);
    cm_valid = cv; cm_arch = 5'(ca); cm_phys = 6'(cp); recover = rc;
    #1;
    chk(src_a_phys == 6'(bspec[a]), {"R2 src_a ", tag}, src_a_phys, bspec[a]);
    chk(src_b_phys == 6'(bspec[b]), {"R2 src_b ", tag}, src_b_phys, bspec[b]);
    chk(ren_ready == (q.size() != 0), {"R5 ready ", tag}, ren_ready, q.size() != 0);
    chk(dst_prev == 6'(bspec[d]), {"R3 prev ", tag}, dst_prev, bspec[d]);
    if (q.size() != 0) chk(dst_phys == 6'(q[0]), {"R3 alloc ", tag}, dst_phys, q[0]);
    @(posedge clk);
    if (rc) begin
      bspec = bcom; rebuild(); ra.delete(); rp.delete();
    end else begin
      if (rv && de && q.size() != 0) begin
        int p = q.pop_front();
        bspec[d] = p; ra.push_back(d); rp.push_back(p);
      end
      if (cv) begin
        void'(ra.pop_front()); void'(rp.pop_front());
        q.push_back(bcom[ca]); bcom[ca] = cp;
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: identity maps and free head after reset
    @(negedge clk); #1;
    chk(dst_phys == 6'd32, "R1 free head", dst_phys, 32);
    chk(ren_ready == 1'b1, "R1 ready", ren_ready, 1);
    for (int i = 0; i < 32; i++) cyc(0, i, 31 - i, 0, i, 0, 0, "R1 reset map");
    // R3/R2: rename every register once, source equal to destination
    for (int i = 0; i < 32; i++) cyc(1, i, (i + 1) % 32, 1, i, 0, 0, "fill");
    // dst_en low: no allocation
    cyc(1, 3, 4, 0, 3, 0, 0, "R3 no dst");
    // R5: empty free list, request ignored
    cyc(1, 5, 6, 1, 5, 0, 0, "R5 stall");
    cyc(0, 5, 6, 0, 5, 0, 0, "R5 after stall");
    // R4: commits release old committed registers
    for (int i = 0; i < 4; i++) cyc(0, i, i, 0, i, 1, 0, "R4 commit");
    // R8: rename and commit together
    for (int i = 0; i < 6; i++) cyc(1, i, 7, 1, 9 + i, 1, 0, "R8 both");
    // R6: recover ignores same-cycle rename and commit
    cyc(1, 2, 3, 1, 2, 1, 1, "R6 recover");
    for (int i = 0; i < 32; i++) cyc(0, i, 31 - i, 0, i, 0, 0, "R6 map");
    // R7: drain rebuilt list in ascending order until empty
    for (int i = 0; i < 34; i++) cyc(1, i % 32, 0, 1, i % 32, 0, 0, "R7 drain");
    // pseudo-random mix of renames, commits and recoveries
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], int'(lf[5:1]), int'(lf[10:6]), lf[11], int'(lf[15:11]),
          lf[12] | lf[2], (lf[7:2] == 6'd0), "mix R1..");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule